// File: doc/BRIEF.md
# Processor Status Word Register

This block holds a 32-bit processor status word. Four condition flags (negative, zero, carry, overflow) are kept as separate flip-flops. A 28-bit control field holds everything else, and its low bits form the processor mode. The read port always presents the packed word. The flags sit in the top nibble and the control field fills the rest.

Software updates the word through a write port that carries a value and a bit mask. If the mask touches the flag nibble at all, all four flags are reloaded from the value. The flag bits are then dropped from the mask, and only the remaining masked bits of the control field take the write value.

When the masked mode bits of a write differ from the stored mode, a one-cycle strobe reports the mode carried in the write value. An ALU port can also load the four flags. A flag-touching software write in the same cycle wins over the ALU.

Top module: `psr_status_reg`

## Requirements
- R1: `rd_data[31:28]` returns the flags as {N,Z,C,V} and `rd_data[27:0]` returns the stored control field.
- R2: A clock edge with `rst` high clears all four flags, loads the control field with `RESET_MODE` zero-extended, and forces `mode_chg` low.
- R3: A write (`wr_en` high) whose mask has any of bits 31..28 set loads all four flags from `wr_data[31:28]`, even when only one of those mask bits is set.
- R4: A write whose mask has none of bits 31..28 set, with no ALU update, leaves the flags unchanged.
- R5: On a write, each control bit 27..0 takes `wr_data` only where the same `wr_mask` bit is 1; all other control bits keep their value.
- R6: `mode_chg` is high for the cycle after a write's clock edge exactly when (stored mode XOR `wr_data[5:0]`) AND `wr_mask[5:0]` is nonzero; otherwise it is low.
- R7: While `mode_chg` is high, `mode_new` equals `wr_data[5:0]` of the causing write, unmerged with the stored mode.
- R8: With `alu_upd` high and no flag-touching write, the flags load `alu_flags` as {N,Z,C,V} = bits 3..0.
- R9: A flag-touching write overrides an ALU update in the same cycle; a write that does not touch the flags lets the ALU update through while the write still updates control bits.
- R10: With `wr_en` low, `wr_data` and `wr_mask` have no effect on the word or on `mode_chg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Write value |
| wr_mask | input | 32 | Per-bit write select |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_flags | input | 4 | ALU flags {N,Z,C,V} |
| rd_data | output | 32 | Packed status word |
| mode_chg | output | 1 | One-cycle mode switch strobe |
| mode_new | output | 6 | Mode value reported with the strobe |

## Verification
The assertions assume that every input is a known value at each clock edge after reset. They also assume the inputs do not move near the edge. A comparison against the cycle before is only made once that cycle was out of reset. The stimulus drives all inputs one time unit after a rising edge and holds them for the full cycle. It asserts reset from time zero with the strobes low, so no check looks at a cycle that is partly undefined.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int WORD_W  = 32;
  localparam int FLAG_W  = 4;
  localparam int CTRL_W  = WORD_W - FLAG_W;
  localparam int FLAG_LO = CTRL_W;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/psr_flag_bank.sv
module psr_flag_bank
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_mask_hi,
  input  logic [FLAG_W-1:0] wr_val_hi,
  input  logic              alu_upd,
  input  logic [FLAG_W-1:0] alu_flags,
  output flags_t            flags
);
  logic sw_hit;
  assign sw_hit = wr_en && (|wr_mask_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (sw_hit) begin
      flags <= flags_t'(wr_val_hi);
    end else if (alu_upd) begin
      flags <= flags_t'(alu_flags);
    end
  end

  // R3
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && ($past(wr_mask_hi) != '0))
      |-> (flags == $past(wr_val_hi)));

  // R8
  alu_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alu_upd) && !($past(wr_en) && ($past(wr_mask_hi) != '0)))
      |-> (flags == $past(alu_flags)));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(alu_upd) && !($past(wr_en) && ($past(wr_mask_hi) != '0)))
      |-> $stable(flags));
endmodule

// File: rtl/psr_ctrl_bank.sv
module psr_ctrl_bank
  import psr_pkg::*;
#(
  parameter int               MODE_W     = 6,
  parameter logic [MODE_W-1:0] RESET_MODE = 6'h10
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_mask_lo,
  input  logic [CTRL_W-1:0] wr_val_lo,
  output logic [CTRL_W-1:0] ctrl,
  output logic              mode_chg,
  output logic [MODE_W-1:0] mode_new
);
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(RESET_MODE);

  logic [CTRL_W-1:0] sel;
  logic [CTRL_W-1:0] ctrl_nx;
  logic              mode_diff;

  assign sel = wr_en ? wr_mask_lo : '0;

  for (genvar b = 0; b < CTRL_W; b++) begin : g_merge
    assign ctrl_nx[b] = sel[b] ? wr_val_lo[b] : ctrl[b];
  end

  assign mode_diff = wr_en &&
    (((ctrl[MODE_W-1:0] ^ wr_val_lo[MODE_W-1:0]) & wr_mask_lo[MODE_W-1:0]) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= CTRL_RST;
      mode_chg <= 1'b0;
      mode_new <= RESET_MODE;
    end else begin
      mode_chg <= mode_diff;
      if (mode_diff) mode_new <= wr_val_lo[MODE_W-1:0];
      ctrl     <= ctrl_nx;
    end
  end

  // R5
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en))
      |-> (((ctrl ^ $past(ctrl)) & ~$past(wr_mask_lo)) == '0));

  // R6
  chg_src_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |-> (!$past(rst) && $past(wr_en)));

  // R7
  mode_val_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |-> (mode_new == $past(wr_val_lo[MODE_W-1:0])));
endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
#(
  parameter int               MODE_W     = 6,
  parameter logic [MODE_W-1:0] RESET_MODE = 6'h10
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] wr_mask,
  input  logic              alu_upd,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic [WORD_W-1:0] rd_data,
  output logic              mode_chg,
  output logic [MODE_W-1:0] mode_new
);
  flags_t            flags;
  logic [CTRL_W-1:0] ctrl;

  psr_flag_bank u_flags (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_mask_hi (wr_mask[WORD_W-1:FLAG_LO]),
    .wr_val_hi  (wr_data[WORD_W-1:FLAG_LO]),
    .alu_upd    (alu_upd),
    .alu_flags  (alu_flags),
    .flags      (flags)
  );

  psr_ctrl_bank #(
    .MODE_W     (MODE_W),
    .RESET_MODE (RESET_MODE)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_mask_lo (wr_mask[CTRL_W-1:0]),
    .wr_val_lo  (wr_data[CTRL_W-1:0]),
    .ctrl       (ctrl),
    .mode_chg   (mode_chg),
    .mode_new   (mode_new)
  );

  assign rd_data = {flags, ctrl};

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> ($stable(rd_data[CTRL_W-1:0]) && !mode_chg));

  // R2
  rst_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == WORD_W'(RESET_MODE) && !mode_chg));
endmodule

// File: tb/psr_status_reg_tb_top.sv
module psr_status_reg_tb_top;
  typedef struct packed {
    logic        en;
    logic [31:0] mask;
    logic [31:0] data;
    logic        av;
    logic [3:0]  af;
    logic [31:0] exp_rd;
    logic        exp_chg;
    logic [5:0]  exp_mode;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R3 full flag mask
    '{1'b1, 32'hF000_0000, 32'hA000_0000, 1'b0, 4'h0, 32'hA000_0010, 1'b0, 6'h00},
    // R3 single flag mask bit loads all four
    '{1'b1, 32'h1000_0000, 32'h5000_0000, 1'b0, 4'h0, 32'h5000_0010, 1'b0, 6'h00},
    // R4 R6 mode write, flags kept
    '{1'b1, 32'h0000_00FF, 32'hFFFF_FF13, 1'b0, 4'h0, 32'h5000_0013, 1'b1, 6'h13},
    // R6 same mode again: no strobe
    '{1'b1, 32'h0000_00FF, 32'hFFFF_FF13, 1'b0, 4'h0, 32'h5000_0013, 1'b0, 6'h00},
    // R7 partial mode mask reports raw value
    '{1'b1, 32'h0000_0001, 32'h0000_002C, 1'b0, 4'h0, 32'h5000_0012, 1'b1, 6'h2C},
    // R5 scattered mask bits
    '{1'b1, 32'h0F00_0F00, 32'hFFFF_FFFF, 1'b0, 4'h0, 32'h5F00_0F12, 1'b0, 6'h00},
    // R8 ALU update alone
    '{1'b0, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'hC, 32'hCF00_0F12, 1'b0, 6'h00},
    // R9 write beats ALU
    '{1'b1, 32'h8000_0000, 32'h3000_0000, 1'b1, 4'hF, 32'h3F00_0F12, 1'b0, 6'h00},
    // R9 non-flag write lets ALU through
    '{1'b1, 32'h0000_00F0, 32'h0000_0000, 1'b1, 4'h8, 32'h8F00_0F02, 1'b1, 6'h00},
    // R10 disabled write ignored
    '{1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'h0, 32'h8F00_0F02, 1'b0, 6'h00},
    // R1 full word write packs back
    '{1'b1, 32'hFFFF_FFFF, 32'h7123_4567, 1'b0, 4'h0, 32'h7123_4567, 1'b1, 6'h27},
    // R6 strobe lasts one cycle
    '{1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'h0, 32'h7123_4567, 1'b0, 6'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] wr_mask = '0;
  logic        alu_upd = 1'b0;
  logic [3:0]  alu_flags = '0;
  logic [31:0] rd_data;
  logic        mode_chg;
  logic [5:0]  mode_new;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psr_status_reg dut_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .alu_upd   (alu_upd),
    .alu_flags (alu_flags),
    .rd_data   (rd_data),
    .mode_chg  (mode_chg),
    .mode_new  (mode_new)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R2 reset state, R1 packing
    check("R2 rd", rd_data, 32'h0000_0010);
    check("R2 chg", {31'b0, mode_chg}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      wr_en = v.en; wr_mask = v.mask; wr_data = v.data;
      alu_upd = v.av; alu_flags = v.af;
      @(posedge clk);
      #1;
      check($sformatf("R1/vec%0d rd", i), rd_data, v.exp_rd);
      check($sformatf("R6/vec%0d chg", i), {31'b0, mode_chg}, {31'b0, v.exp_chg});
      if (v.exp_chg)
        check($sformatf("R7/vec%0d mode", i), {26'b0, mode_new}, {26'b0, v.exp_mode});
    end

    // R2 reset wins over a concurrent write
    rst = 1'b1; wr_en = 1'b1; wr_mask = '1; wr_data = 32'hFFFF_FFEE;
    alu_upd = 1'b1; alu_flags = 4'hF;
    @(posedge clk);
    #1;
    rst = 1'b0; wr_en = 1'b0; alu_upd = 1'b0;
    check("R2 mid rd", rd_data, 32'h0000_0010);
    check("R2 mid chg", {31'b0, mode_chg}, 32'h0);

    // R3 R6 flag-only write to mode-equal state: no strobe, flags load
    wr_en = 1'b1; wr_mask = 32'h2000_003F; wr_data = 32'h2000_0010;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    check("R3 flags", rd_data, 32'h2000_0010);
    check("R6 equal mode", {31'b0, mode_chg}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule